// File: doc/BRIEF.md
# Mask-Selected Register Block Transfer Sequencer

This block moves data between a register file of up to 64 entries and a packed block of memory. Software supplies a selection mask with one bit per register, a base address and a direction, then pulses `start`. The sequencer walks the register indices from lowest to highest. For every index whose mask bit is set, it performs one memory access.

A load takes the next memory word and writes it into that register. A store reads that register and writes it to the next memory word. The memory side is dense: each access uses the next word address, with no holes. The register side is sparse: indices whose mask bit is clear are passed over and are never touched.

The memory port uses a request/acknowledge handshake, and the sequencer waits as long as the acknowledge takes. Register file reads are combinational. When the last selected register has been moved, `done` pulses for one cycle.

Top module: `mask_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_req` and `rf_we` are all low.
- R2: Selected registers are transferred in strictly ascending index order. On a store, `mem_we` is 1, `rf_raddr` carries the register index, and `mem_wdata` carries that register's value.
- R3: The first access goes to `base_addr`. Each completed access moves the address on by 8 bytes, so the n-th transfer (counting from 0) uses `base_addr + 8*n`.
- R4: On a load (`is_store` = 0), `rf_we` pulses in the cycle of each acknowledged request, with `rf_waddr` set to the selected index and `rf_wdata` set to `mem_rdata`. A register whose mask bit is zero is never written.
- R5: A raised `mem_req` stays high, with address, direction and register index unchanged, until `mem_ack` is seen with it.
- R6: Unselected indices cost no cycles. With `mem_ack` always granted, a mask with k set bits raises `done` exactly k+1 clock edges after the edge that sampled `start`.
- R7: An all-zero mask raises `done` in the first busy cycle and makes no memory request.
- R8: `done` lasts exactly one cycle, after which `busy` is low.
- R9: A `start` pulse while `busy` is high is ignored. The transfer in progress keeps its mask, direction and address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| is_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| mask | input | NREG | Register selection, bit i selects register i |
| base_addr | input | AW | Byte address of the first memory word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Store data |
| mem_ack | input | 1 | Memory accepts/completes the access this cycle |
| mem_rdata | input | DW | Load data, valid with `mem_ack` |
| rf_raddr | output | IW | Register file read index |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | IW | Register file write index |
| rf_wdata | output | DW | Register file write data |

## Verification
Several properties are checked on every cycle. A waiting request must hold steady, and each acknowledged access must move the address on by exactly one word. The register index must rise from one access to the next, register writes may happen only on acknowledged loads, `done` must last a single cycle, and the direction must stay fixed while busy.

Other properties can only be shown by the bench's scenarios, which sweep single-bit, dense, sparse and pseudo-random masks in both directions, with and without wait states. These are:
- exact placement of data, meaning which memory word lands in which register and which words and registers stay untouched;
- cycle counts that prove skipped indices cost nothing;
- the zero-mask case;
- a transfer surviving a `start` pulse that arrives mid-way.

// File: rtl/mask_xfer_seq.sv
module mask_xfer_seq #(
  parameter int NREG   = 64,
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int WBYTES = 8,
  localparam int IW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_store,
  input  logic [NREG-1:0] mask,
  input  logic [AW-1:0]   base_addr,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata
);

  logic            busy_q;
  logic            st_q;
  logic [NREG-1:0] pend;
  logic [AW-1:0]   addr_q;
  logic [IW-1:0]   idx;
  logic            have;

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend[i]) idx = IW'(i);
  end

  assign have      = |pend;
  assign busy      = busy_q;
  assign done      = busy_q && !have;
  assign mem_req   = busy_q && have;
  assign mem_we    = st_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = rf_rdata;
  assign rf_raddr  = idx;
  assign rf_we     = mem_req && mem_ack && !st_q;
  assign rf_waddr  = idx;
  assign rf_wdata  = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      st_q   <= 1'b0;
      pend   <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        st_q   <= is_store;
        pend   <= mask;
        addr_q <= base_addr;
      end
    end else if (!have) begin
      busy_q <= 1'b0;
    end else if (mem_ack) begin
      pend[idx] <= 1'b0;
      addr_q    <= addr_q + AW'(WBYTES);
    end
  end

  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(rf_raddr) && $stable(mem_we));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> mem_addr == $past(mem_addr) + AW'(WBYTES));

  // R2
  order_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || (rf_raddr > $past(rf_raddr)));

  // R4
  rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_req && mem_ack && !mem_we);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_we));

endmodule

// File: tb/mask_xfer_seq_test.sv
`timescale 1ns/1ps
module mask_xfer_seq_test;
  localparam int NREG = 64;
  localparam int AW   = 32;
  localparam int DW   = 64;
  localparam int IW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            is_store = 1'b0;
  logic [NREG-1:0] mask = '0;
  logic [AW-1:0]   base_addr = '0;
  logic            busy, done, mem_req, mem_we, mem_ack, rf_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [IW-1:0]   rf_raddr, rf_waddr;

  logic [DW-1:0] mem_arr [NREG];
  logic [DW-1:0] rf_arr  [NREG];
  logic [AW-1:0] acc_addr [NREG];
  logic [IW-1:0] acc_idx  [NREG];
  int            acc_cnt;
  logic          ack_slow = 1'b0;
  logic          tog = 1'b0;
  logic [AW-1:0] off;
  int            pass_n = 0;
  int            total_n = 0;
  logic [63:0]   lfsr = 64'hACE1_1234_5678_9ABD;

  always #2.5 clk = ~clk;

  mask_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .mask(mask),
    .base_addr(base_addr), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign off       = mem_addr - base_addr;
  assign mem_ack   = mem_req && (!ack_slow || tog);
  assign mem_rdata = mem_arr[off[8:3]];
  assign rf_rdata  = rf_arr[rf_raddr];

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req && mem_ack) begin
      if (acc_cnt < NREG) begin
        acc_addr[acc_cnt] <= mem_addr;
        acc_idx[acc_cnt]  <= rf_raddr;
      end
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem_arr[off[8:3]] <= mem_wdata;
    end
    if (rf_we) rf_arr[rf_waddr] <= rf_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic run(input logic [NREG-1:0] m, input bit st, input bit slow,
                     input logic [AW-1:0] base, input int seed, input bit intr);
    logic [DW-1:0] exp_mem [NREG];
    logic [DW-1:0] exp_rf  [NREG];
    int k, n, bad_a, bad_i, bad_d;
    logic [DW-1:0] bad_act, bad_exp;
    for (int j = 0; j < NREG; j++) begin
      mem_arr[j] = {16'hC0DE, 16'(seed), 24'h0, 8'(j)};
      rf_arr[j]  = {16'h5EED, 16'(seed), 24'h0, 8'(j)};
      exp_mem[j] = mem_arr[j];
      exp_rf[j]  = rf_arr[j];
    end
    k = 0;
    for (int i = 0; i < NREG; i++)
      if (m[i]) begin
        if (st) exp_mem[k] = rf_arr[i]; else exp_rf[i] = mem_arr[k];
        k++;
      end
    acc_cnt = 0;
    ack_slow = slow;
    @(negedge clk);
    mask = m; is_store = st; base_addr = base; start = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 2000) begin
      if (intr && n == 3) begin
        start = 1'b1; mask = ~m; is_store = ~st;
      end else begin
        start = 1'b0; mask = m; is_store = st;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0; mask = m; is_store = st;
    chk(done, "R8 done seen", 64'(done), 64'd1);
    if (!slow && !intr)
      chk(n == k + 1, (k == 0) ? "R7 zero-mask latency" : "R6 latency", 64'(n), 64'(k + 1));
    @(negedge clk);
    chk(!done && !busy, "R8 done single cycle", {62'b0, done, busy}, 64'd0);
    chk(acc_cnt == k, (k == 0) ? "R7 no access" : "R9 access count", 64'(acc_cnt), 64'(k));
    bad_a = 0; bad_i = 0;
    k = 0;
    for (int i = 0; i < NREG; i++)
      if (m[i]) begin
        if (k < acc_cnt) begin
          if (acc_addr[k] != base + AW'(8 * k)) bad_a++;
          if (acc_idx[k] != IW'(i)) bad_i++;
        end
        k++;
      end
    chk(bad_a == 0, "R3 address sequence", 64'(bad_a), 64'd0);
    chk(bad_i == 0, "R2 register order", 64'(bad_i), 64'd0);
    bad_d = 0; bad_act = '0; bad_exp = '0;
    for (int j = 0; j < NREG; j++) begin
      if (st && mem_arr[j] != exp_mem[j]) begin
        if (bad_d == 0) begin bad_act = mem_arr[j]; bad_exp = exp_mem[j]; end
        bad_d++;
      end
      if (rf_arr[j] != exp_rf[j]) begin
        if (bad_d == 0) begin bad_act = rf_arr[j]; bad_exp = exp_rf[j]; end
        bad_d++;
      end
    end
    chk(bad_d == 0, st ? "R2 store contents" : "R4 load contents", bad_act, bad_exp);
  endtask

  initial begin
    #(5.0 * 200000);
    total_n++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    int seed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1 reset state",
        {60'b0, busy, done, mem_req, rf_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1 idle after reset",
        {60'b0, busy, done, mem_req, rf_we}, 64'd0);
    for (int d = 0; d < 2; d++) begin
      run('0, d[0], 1'b0, 32'h4000, seed++, 1'b0);
      run('1, d[0], 1'b0, 32'h4000, seed++, 1'b0);
      run('1, d[0], 1'b1, 32'h8000, seed++, 1'b0);
      run(64'hAAAA_AAAA_AAAA_AAAA, d[0], 1'b0, 32'h1008, seed++, 1'b0);
      run(64'h8000_0000_0000_0001, d[0], 1'b1, 32'h2000, seed++, 1'b0);
      run(64'h0000_FFFF_0000_F0F0, d[0], 1'b0, 32'h3000, seed++, 1'b1);
      for (int b = 0; b < NREG; b++)
        run(64'd1 << b, d[0], b[0], 32'h5000 + 32'(8 * b), seed++, 1'b0);
      for (int r = 0; r < 20; r++) begin
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        lfsr = {lfsr[31:0], lfsr[63:32] ^ {lfsr[30:0], lfsr[31]}};
        run(lfsr & {lfsr[31:0], lfsr[63:32]} | 64'(r), d[0], r[0], 32'h6000 + 32'(r * 16),
            seed++, r[2]);
      end
    end
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule